// File: doc/BRIEF.md
# Four-Lane Alignment-Column Inserter with Per-Lane Scrambling

This block sits on the transmit side of a link that stripes bytes over four lanes. Each clock it takes one column (one byte per lane), a per-lane control flag and a gap indicator. It returns one column per clock, one cycle later. Every lane has its own additive scrambler. Data and control bytes both pass through it, so the line carries no long repeating control pattern.

At a fixed interval the receiver needs a marker it can find on every lane at the same instant, in order to deskew the lanes. Once that interval has elapsed, the block waits for the next idle column. It then puts three unscrambled columns on the line in place of idle input: all lanes A (8'h17), then all lanes K (8'h4E), then all lanes R (8'h74). The incoming idle bytes at those positions are dropped, so one column still leaves for every column that arrives and the line rate does not change. On the R column every lane scrambler is reloaded with its seed. The receiver can therefore restart its descramblers from the marker. If the gap closes before the marker is complete, the block flags the short gap, resumes normal scrambled traffic and tries again at the next gap.

Top module: `lane_align_scrambler`

## Requirements
- R1: While reset is high, and on the first column after it, every output byte is 8'h00 and short_gap_o is low.
- R2: Output lags input by one clock. For a column that is not replaced, lane n outputs its input byte XOR a keystream byte from lane n's generator. The generator is a 7-bit additive register for x^7+x^6+1, seeded 7'h7F. Per bit, fb = s[6]^s[5]: fb is the keystream bit and s becomes {s[5:0],fb}. Keystream bit 0 is produced first. The generator advances by one byte for each scrambled column.
- R3: A byte whose control flag is set is scrambled exactly like a data byte.
- R4: A marker becomes due once PERIOD scrambled columns have passed since reset or since the last completed marker. A column is idle when gap_i is high and every lane's control flag is high. At the first idle column while a marker is due, three consecutive idle columns are replaced by A (8'h17), K (8'h4E) and R (8'h74) on every lane, unscrambled.
- R5: Input bytes replaced by the marker are discarded, and no lane generator advances during the marker columns.
- R6: On the R column every generator is reloaded with 7'h7F, so the next scrambled column uses the seed keystream.
- R7: While a marker is due, a column that is not idle is passed scrambled and the marker waits.
- R8: If a non-idle column arrives in the K or R slot, that column is passed scrambled and short_gap_o is high with it. No reload happens, and the marker stays due for the next idle column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| col_data_i | input | LANES*8 | Input column, lane n at bits [8n+7:8n] |
| col_ctrl_i | input | LANES | Per-lane control flag |
| gap_i | input | 1 | High during an inter-packet gap |
| col_data_o | output | LANES*8 | Output column, same lane layout |
| short_gap_o | output | 1 | Marker aborted because the gap ended early |

## Verification
A generator that holds a wrong state corrupts every scrambled byte on its lane from the next column onward. The error lasts until the next R column reloads the seed, so it cannot hide for more than a marker period. A wrong interval count or a wrong sequencing state moves the A-K-R columns or breaks them up. This shows on the port within PERIOD columns of the point where the marker should have appeared. A generator that advances while the marker is on the line is exposed by the column that follows an aborted marker.

// File: rtl/idlealign_pkg.sv
package idlealign_pkg;
  localparam int SCR_W = 7;
  localparam logic [SCR_W-1:0] SCR_SEED = 7'h7F;
  localparam logic [7:0] CH_A = 8'h17;
  localparam logic [7:0] CH_K = 8'h4E;
  localparam logic [7:0] CH_R = 8'h74;

  typedef enum logic [1:0] {SEL_DATA, SEL_A, SEL_K, SEL_R} col_sel_t;

  // One byte step of the x^7+x^6+1 additive generator: {next state, keystream}
  function automatic logic [SCR_W+7:0] scr_step(input logic [SCR_W-1:0] s_in);
    logic [SCR_W-1:0] s;
    logic [7:0]       ks;
    logic             fb;
    s  = s_in;
    ks = '0;
    for (int b = 0; b < 8; b++) begin
      fb    = s[6] ^ s[5];
      ks[b] = fb;
      s     = {s[5:0], fb};
    end
    return {s, ks};
  endfunction
endpackage

// File: rtl/las_lane_scr.sv
module las_lane_scr
  import idlealign_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       adv_i,
  input  logic       reseed_i,
  input  logic [7:0] byte_i,
  output logic [7:0] byte_o
);
  logic [SCR_W-1:0] st_q;
  logic [SCR_W+7:0] step;

  assign step   = scr_step(st_q);
  assign byte_o = byte_i ^ step[7:0];

  always_ff @(posedge clk) begin
    if (rst || reseed_i) st_q <= SCR_SEED;
    else if (adv_i)      st_q <= step[SCR_W+7:8];
  end
endmodule

// File: rtl/las_sequencer.sv
module las_sequencer
  import idlealign_pkg::*;
#(
  parameter int PERIOD = 2048
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     idle_i,
  output col_sel_t sel_o,
  output logic     adv_o,
  output logic     reseed_o,
  output logic     abort_o
);
  localparam int CW = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] CNT_DUE = CW'(PERIOD);

  typedef enum logic [1:0] {PH_PASS, PH_K, PH_R} phase_t;

  phase_t        ph_q, ph_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          due;

  assign due = (cnt_q == CNT_DUE);

  always_comb begin
    sel_o    = SEL_DATA;
    adv_o    = 1'b1;
    reseed_o = 1'b0;
    abort_o  = 1'b0;
    ph_n     = ph_q;
    cnt_n    = cnt_q;
    case (ph_q)
      PH_PASS: begin
        if (due && idle_i) begin
          sel_o = SEL_A;
          adv_o = 1'b0;
          ph_n  = PH_K;
        end else if (!due) begin
          cnt_n = cnt_q + CW'(1);
        end
      end
      PH_K: begin
        if (idle_i) begin
          sel_o = SEL_K;
          adv_o = 1'b0;
          ph_n  = PH_R;
        end else begin
          abort_o = 1'b1;
          ph_n    = PH_PASS;
        end
      end
      PH_R: begin
        if (idle_i) begin
          sel_o    = SEL_R;
          adv_o    = 1'b0;
          reseed_o = 1'b1;
          ph_n     = PH_PASS;
          cnt_n    = '0;
        end else begin
          abort_o = 1'b1;
          ph_n    = PH_PASS;
        end
      end
      default: ph_n = PH_PASS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_PASS;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_n;
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/lane_align_scrambler.sv
module lane_align_scrambler
  import idlealign_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int PERIOD = 2048
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LANES*8-1:0] col_data_i,
  input  logic [LANES-1:0]   col_ctrl_i,
  input  logic               gap_i,
  output logic [LANES*8-1:0] col_data_o,
  output logic               short_gap_o
);
  col_sel_t           seq_sel;
  logic               seq_adv, seq_reseed, seq_abort;
  logic               idle_col;
  logic [LANES*8-1:0] scr_col;
  logic [LANES*8-1:0] data_q;
  logic               err_q;

  assign idle_col = gap_i & (&col_ctrl_i);

  las_sequencer #(.PERIOD(PERIOD)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .idle_i   (idle_col),
    .sel_o    (seq_sel),
    .adv_o    (seq_adv),
    .reseed_o (seq_reseed),
    .abort_o  (seq_abort)
  );

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    las_lane_scr u_scr (
      .clk      (clk),
      .rst      (rst),
      .adv_i    (seq_adv),
      .reseed_i (seq_reseed),
      .byte_i   (col_data_i[8*n +: 8]),
      .byte_o   (scr_col[8*n +: 8])
    );

    always_ff @(posedge clk) begin
      if (rst) data_q[8*n +: 8] <= 8'h00;
      else begin
        case (seq_sel)
          SEL_A:   data_q[8*n +: 8] <= CH_A;
          SEL_K:   data_q[8*n +: 8] <= CH_K;
          SEL_R:   data_q[8*n +: 8] <= CH_R;
          default: data_q[8*n +: 8] <= scr_col[8*n +: 8];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= seq_abort;
  end

  assign col_data_o  = data_q;
  assign short_gap_o = err_q;
endmodule

// File: rtl/las_checker.sv
module las_checker
  import idlealign_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [LANES*8-1:0] col_data_o,
  input logic [LANES-1:0]   col_ctrl_i,
  input logic               gap_i,
  input logic               short_gap_o,
  input col_sel_t           sel
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (col_data_o == '0) && !short_gap_o);

  // R4
  mark_a_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_A) |=> (col_data_o == {LANES{CH_A}}));

  // R4
  mark_k_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_K) |=> (col_data_o == {LANES{CH_K}}));

  // R4
  mark_r_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_R) |=> (col_data_o == {LANES{CH_R}}));

  // R7
  mark_on_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (sel != SEL_DATA) |-> (gap_i && (&col_ctrl_i)));

  // R8
  short_gap_cause_chk: assert property (@(posedge clk) disable iff (rst)
    short_gap_o |-> !$past(gap_i && (&col_ctrl_i)));
endmodule

bind lane_align_scrambler las_checker #(.LANES(LANES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .col_data_o  (col_data_o),
  .col_ctrl_i  (col_ctrl_i),
  .gap_i       (gap_i),
  .short_gap_o (short_gap_o),
  .sel         (seq_sel)
);

// File: tb/tb_lane_align_scrambler.sv
`timescale 1ns/1ps
module tb_lane_align_scrambler;
  localparam int LANES = 4;
  localparam int PER   = 8;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [LANES*8-1:0] din = '0;
  logic [LANES-1:0]   ctl = '0;
  logic               gap = 1'b0;
  logic [LANES*8-1:0] dout;
  logic               sgap;

  int checks = 0;
  int errors = 0;
  int col_no = 0;

  // reference model state
  logic [6:0]         m_st  = 7'h7F;
  int                 m_cnt = 0;
  int                 m_ph  = 0;
  bit                 m_after_r = 0;
  bit                 have_exp = 0;
  logic [LANES*8-1:0] e_data;
  logic               e_err;
  string              e_tag;

  always #2.5 clk = ~clk;

  lane_align_scrambler #(.LANES(LANES), .PERIOD(PER)) dut (
    .clk(clk), .rst(rst), .col_data_i(din), .col_ctrl_i(ctl), .gap_i(gap),
    .col_data_o(dout), .short_gap_o(sgap)
  );

  function automatic logic [7:0] key_of(input logic [6:0] s);
    logic [6:0] t = s;
    logic [7:0] k = '0;
    for (int b = 0; b < 8; b++) begin
      k[b] = t[6] ^ t[5];
      t = {t[5:0], k[b]};
    end
    return k;
  endfunction

  function automatic logic [6:0] next_of(input logic [6:0] s);
    logic [6:0] t = s;
    for (int b = 0; b < 8; b++) t = {t[5:0], t[6] ^ t[5]};
    return t;
  endfunction

  task automatic compare();
    checks++;
    if (dout !== e_data || sgap !== e_err) begin
      errors++;
      $display("FAIL %s col=%0d got data=%h err=%b exp data=%h err=%b",
               e_tag, col_no, dout, sgap, e_data, e_err);
    end
  endtask

  task automatic scramble_col(input logic [LANES*8-1:0] d);
    for (int n = 0; n < LANES; n++) e_data[8*n +: 8] = d[8*n +: 8] ^ key_of(m_st);
    m_st = next_of(m_st);
  endtask

  // Entered at a falling edge: check the previous column, model and drive a new one.
  task automatic drive_col(input logic [LANES*8-1:0] d, input logic [LANES-1:0] c,
                           input logic g);
    bit idle;
    if (have_exp) compare();
    idle  = g && (&c);
    e_err = 1'b0;
    e_tag = (|c) ? "R3" : "R2";
    if (m_after_r) e_tag = "R6";
    m_after_r = 0;
    case (m_ph)
      0: begin
        if (m_cnt == PER && idle) begin
          e_data = {LANES{8'h17}}; m_ph = 1; e_tag = "R4";
        end else begin
          if (m_cnt == PER) e_tag = "R7";
          scramble_col(d);
          if (m_cnt < PER) m_cnt++;
        end
      end
      default: begin
        if (idle) begin
          if (m_ph == 1) begin
            e_data = {LANES{8'h4E}}; m_ph = 2;
          end else begin
            e_data = {LANES{8'h74}}; m_ph = 0; m_st = 7'h7F; m_cnt = 0; m_after_r = 1;
          end
          e_tag = "R4";
        end else begin
          scramble_col(d); e_err = 1'b1; m_ph = 0; e_tag = "R5,R8";
        end
      end
    endcase
    din = d; ctl = c; gap = g;
    have_exp = 1;
    col_no++;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs cleared under reset
    checks++;
    if (dout !== '0 || sgap !== 1'b0) begin
      errors++;
      $display("FAIL R1 got data=%h err=%b exp data=%h err=%b", dout, sgap, '0, 1'b0);
    end
    rst = 1'b0;
    for (int rep = 0; rep < 4; rep++) begin
      for (int g = 0; g < 6; g++) begin
        for (int i = 0; i < 10; i++) begin
          logic [LANES*8-1:0] d;
          logic [LANES-1:0]   c;
          for (int n = 0; n < LANES; n++)
            d[8*n +: 8] = 8'((i * 37) + (n * 11) + (rep * 5) + (g * 3));
          c = (i % 3 == 0) ? 4'b0101 : 4'b0000;
          drive_col(d, c, 1'b0);
        end
        for (int j = 0; j < g; j++) begin
          // a gap column with one lane not marked control is not idle (R7)
          if (g == 5 && j == 0) drive_col({LANES{8'h07}}, 4'b1110, 1'b1);
          else                  drive_col({LANES{8'h07}}, 4'b1111, 1'b1);
        end
      end
    end
    drive_col({LANES{8'h5A}}, 4'b0000, 1'b0);
    compare();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule